// File: doc/BRIEF.md
# Paged Memory Window Translator

This block sits between a 16-bit CPU bus and a 22-bit physical memory bus. Most CPU addresses map straight through, with zeros in the upper physical bits. Addresses from 0x8000 to 0xBFFF form a 16 KB bank window. An access there reaches the 16 KB physical page named by an 8-bit bank register. The physical address is the bank number followed by the low 14 address bits.

A side port handles long subroutine calls and returns. A long call pushes the current bank onto an internal last-in-first-out store of eight entries and loads the target bank. A long return pops the saved bank back into the bank register. Pushing when the store is full, or popping when it is empty, sets a sticky fault flag and changes neither the store nor the bank.

A second route reaches the whole 4 MB physical space as one flat array. Software loads a 22-bit linear pointer through three byte registers, then reads or writes a data port. Each data-port access goes to the pointer's address and advances the pointer by one, wrapping from 0x3FFFFF to zero. The five control registers sit at fixed low CPU addresses starting at parameter `REG_BASE` (default 0x0070):

- +0 bank register
- +1 pointer bits 21:16, in bits 5:0 of the byte
- +2 pointer bits 15:8
- +3 pointer bits 7:0
- +4 data port

Top module: `pagewin_xlat`

## Requirements
- R1: After synchronous reset the bank register is 0, the linear pointer is 0, the fault flag is low and the save store is empty.
- R2: A CPU address from 0x8000 to 0xBFFF drives `mem_addr` = {bank[7:0], cpu_addr[13:0]} in the same cycle, with `mem_en` high when `cpu_en` is high.
- R3: Any other CPU address outside the register block drives `mem_addr` = {6'b0, cpu_addr}, and the access reaches memory unchanged in direction and data.
- R4: A CPU write to REG_BASE+0 sets the bank register, which first steers the window on the next cycle. A read of REG_BASE+0 returns the bank.
- R5: A long call (`far_call` high) with a non-full store pushes the current bank and loads `far_page` into the bank register for the next cycle.
- R6: A long return (`far_ret` high) with a non-empty store loads the most recently pushed bank into the bank register for the next cycle.
- R7: A long call with eight entries stored sets the fault flag and leaves the bank and the store unchanged.
- R8: A long return with an empty store sets the fault flag and leaves the bank unchanged. The fault flag stays high until reset.
- R9: CPU writes to REG_BASE+1, +2 and +3 load pointer bits 21:16, 15:8 and 7:0. Reads of those addresses return the same fields, with bits 7:6 of REG_BASE+1 reading as zero.
- R10: A read or write at REG_BASE+4 drives `mem_addr` with the pointer and `mem_en` high. The read returns `mem_rdata`. The pointer advances by one for the next cycle.
- R11: The pointer advance wraps from 0x3FFFFF to 0x000000.
- R12: An access to REG_BASE+0 through +3 keeps `mem_en` and `mem_we` low. The CPU read data comes from the register, not from memory.
- R13: When `far_call` and `far_ret` are high together, only the call acts. When either is high, a CPU write to the bank register in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_en | input | 1 | CPU access valid this cycle |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, from a register or from memory |
| mem_en | output | 1 | Physical memory access valid |
| mem_we | output | 1 | Physical memory write |
| mem_addr | output | 22 | Physical address |
| mem_wdata | output | 8 | Physical write data |
| mem_rdata | input | 8 | Physical read data (combinational) |
| far_call | input | 1 | Long call: save bank, load far_page |
| far_ret | input | 1 | Long return: restore saved bank |
| far_page | input | 8 | Target bank of a long call |
| page_o | output | 8 | Current bank register |
| stk_err | output | 1 | Sticky save-store fault |

## Verification
The bench targets the window edges 0x7FFF, 0x8000, 0xBFFF and 0xC000. A comparator that is off by one there would put an edge byte in the wrong bank or pass a window byte through flat.

It fills the save store to exactly eight entries and then pushes once more. It also pops an empty store. A design that wrapped its depth counter would silently corrupt the bank instead of raising the fault, or would drop the fault on a later good call.

The pointer is parked at 0x3FFFFE and stepped past the top. A carry leaking beyond 22 bits, or a missed step on writes, shows up as a wrong physical address.

Same-cycle calls, returns and bank writes check the priority order. A random mix is compared against a queue-based model on every cycle.

// File: rtl/pagewin_pkg.sv
package pagewin_pkg;

    localparam int CPU_AW  = 16;
    localparam int DATA_W  = 8;
    localparam int PAGE_W  = 8;
    localparam int OFF_W   = 14;
    localparam int PHYS_W  = PAGE_W + OFF_W;
    localparam int HI_W    = PHYS_W - 16;
    localparam int NUM_REG = 5;

    localparam logic [CPU_AW-1:0] WIN_FIRST = 16'h8000;
    localparam logic [CPU_AW-1:0] WIN_LAST  = 16'hBFFF;

    // register offsets from the register block base
    localparam logic [CPU_AW-1:0] OFS_BANK = 16'd0;
    localparam logic [CPU_AW-1:0] OFS_PHI  = 16'd1;
    localparam logic [CPU_AW-1:0] OFS_PMID = 16'd2;
    localparam logic [CPU_AW-1:0] OFS_PLO  = 16'd3;
    localparam logic [CPU_AW-1:0] OFS_PORT = 16'd4;

    typedef enum logic [2:0] {
        SEL_MEM,
        SEL_BANK,
        SEL_PHI,
        SEL_PMID,
        SEL_PLO,
        SEL_PORT
    } sel_e;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [CPU_AW-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cpu_req_t;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [PHYS_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } mem_req_t;

    function automatic logic in_window(input logic [CPU_AW-1:0] a);
        return (a >= WIN_FIRST) && (a <= WIN_LAST);
    endfunction

    function automatic logic [PHYS_W-1:0] banked(input logic [PAGE_W-1:0] pg,
                                                 input logic [OFF_W-1:0]  ofs);
        return {pg, ofs};
    endfunction

    function automatic logic [PHYS_W-1:0] flat(input logic [CPU_AW-1:0] a);
        return {{(PHYS_W-CPU_AW){1'b0}}, a};
    endfunction

endpackage

// File: rtl/pw_decode.sv
module pw_decode
    import pagewin_pkg::*;
#(
    parameter logic [15:0] REG_BASE = 16'h0070
) (
    input  logic [CPU_AW-1:0] addr,
    output sel_e              sel
);
    logic [CPU_AW-1:0] ofs;
    logic              in_blk;

    always_comb begin
        ofs    = addr - REG_BASE;
        in_blk = (addr >= REG_BASE) && (ofs < CPU_AW'(NUM_REG));
        sel    = SEL_MEM;
        if (in_blk) begin
            unique case (ofs)
                OFS_BANK: sel = SEL_BANK;
                OFS_PHI:  sel = SEL_PHI;
                OFS_PMID: sel = SEL_PMID;
                OFS_PLO:  sel = SEL_PLO;
                OFS_PORT: sel = SEL_PORT;
                default:  sel = SEL_MEM;
            endcase
        end
    end
endmodule

// File: rtl/pw_bank_stack.sv
module pw_bank_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty,
    output logic         err
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     store [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic             push_ok, pop_ok;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !push && !empty;
    assign top     = empty ? '0 : store[IDX_W'(cnt - 1'b1)];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[IDX_W'(cnt)] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            err <= 1'b0;
        end else begin
            if (push_ok) begin
                cnt <= cnt + 1'b1;
            end else if (pop_ok) begin
                cnt <= cnt - 1'b1;
            end
            if ((push && full) || (pop && !push && empty)) begin
                err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pw_lin_ptr.sv
module pw_lin_ptr
    import pagewin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_hi,
    input  logic              ld_mid,
    input  logic              ld_lo,
    input  logic              advance,
    input  logic [DATA_W-1:0] wdata,
    output logic [PHYS_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= ptr + 1'b1;
        end else begin
            if (ld_hi)  ptr[PHYS_W-1:16] <= wdata[HI_W-1:0];
            if (ld_mid) ptr[15:8]        <= wdata;
            if (ld_lo)  ptr[7:0]         <= wdata;
        end
    end
endmodule

// File: rtl/pagewin_xlat.sv
module pagewin_xlat
    import pagewin_pkg::*;
#(
    parameter logic [15:0] REG_BASE  = 16'h0070,
    parameter int          STK_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_en,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        mem_en,
    output logic        mem_we,
    output logic [21:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        far_call,
    input  logic        far_ret,
    input  logic [7:0]  far_page,
    output logic [7:0]  page_o,
    output logic        stk_err
);
    cpu_req_t          req;
    mem_req_t          mreq;
    sel_e              sel;
    logic [PAGE_W-1:0] bank;
    logic [PAGE_W-1:0] stk_top;
    logic              stk_full, stk_empty;
    logic [PHYS_W-1:0] lptr;
    logic              wr_cyc, bank_wr, do_pop;

    assign req = '{en: cpu_en, we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};

    pw_decode #(.REG_BASE(REG_BASE)) u_dec (
        .addr (req.addr),
        .sel  (sel)
    );

    assign do_pop = far_ret && !far_call;

    pw_bank_stack #(.DEPTH(STK_DEPTH), .W(PAGE_W)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (far_call),
        .pop   (do_pop),
        .din   (bank),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty),
        .err   (stk_err)
    );

    assign wr_cyc = req.en && req.we;

    pw_lin_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .ld_hi   (wr_cyc && (sel == SEL_PHI)),
        .ld_mid  (wr_cyc && (sel == SEL_PMID)),
        .ld_lo   (wr_cyc && (sel == SEL_PLO)),
        .advance (req.en && (sel == SEL_PORT)),
        .wdata   (req.wdata),
        .ptr     (lptr)
    );

    assign bank_wr = wr_cyc && (sel == SEL_BANK) && !far_call && !far_ret;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= '0;
        end else if (far_call) begin
            if (!stk_full) bank <= far_page;
        end else if (do_pop) begin
            if (!stk_empty) bank <= stk_top;
        end else if (bank_wr) begin
            bank <= req.wdata;
        end
    end

    always_comb begin
        mreq.wdata = req.wdata;
        unique case (sel)
            SEL_PORT: begin
                mreq.en   = req.en;
                mreq.addr = lptr;
            end
            SEL_MEM: begin
                mreq.en   = req.en;
                mreq.addr = in_window(req.addr) ? banked(bank, req.addr[OFF_W-1:0])
                                                : flat(req.addr);
            end
            default: begin
                mreq.en   = 1'b0;
                mreq.addr = flat(req.addr);
            end
        endcase
        mreq.we = mreq.en && req.we;
    end

    always_comb begin
        unique case (sel)
            SEL_BANK: cpu_rdata = bank;
            SEL_PHI:  cpu_rdata = DATA_W'(lptr[PHYS_W-1:16]);
            SEL_PMID: cpu_rdata = lptr[15:8];
            SEL_PLO:  cpu_rdata = lptr[7:0];
            default:  cpu_rdata = mem_rdata;
        endcase
    end

    assign mem_en    = mreq.en;
    assign mem_we    = mreq.we;
    assign mem_addr  = mreq.addr;
    assign mem_wdata = mreq.wdata;
    assign page_o    = bank;
endmodule

// File: rtl/pagewin_chk.sv
module pagewin_chk #(
    parameter logic [15:0] REG_BASE = 16'h0070
) (
    input logic        clk,
    input logic        rst,
    input logic        cpu_en,
    input logic [15:0] cpu_addr,
    input logic        mem_en,
    input logic [21:0] mem_addr,
    input logic [7:0]  page_o,
    input logic        stk_err,
    input logic        far_call,
    input logic [7:0]  far_page,
    input logic        stk_full,
    input logic [21:0] lptr
);
    logic in_win, in_regs, ctl_reg, port_reg;

    assign in_win   = (cpu_addr >= 16'h8000) && (cpu_addr <= 16'hBFFF);
    assign in_regs  = (cpu_addr >= REG_BASE) && (cpu_addr <= REG_BASE + 16'd4);
    assign ctl_reg  = (cpu_addr >= REG_BASE) && (cpu_addr <= REG_BASE + 16'd3);
    assign port_reg = (cpu_addr == REG_BASE + 16'd4);

    assert_window_map_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && in_win && !in_regs) |-> (mem_en && mem_addr == {page_o, cpu_addr[13:0]}));

    assert_pass_through_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && !in_win && !in_regs) |-> (mem_en && mem_addr == {6'b0, cpu_addr}));

    assert_call_load_R5: assert property (@(posedge clk) disable iff (rst)
        (far_call && !stk_full) |=> (page_o == $past(far_page)));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (far_call && stk_full) |=> (stk_err && page_o == $past(page_o)));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        stk_err |=> stk_err);

    assert_ptr_step_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && port_reg) |=> (lptr == $past(lptr) + 22'd1));

    assert_port_addr_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && port_reg) |-> (mem_en && mem_addr == lptr));

    assert_reg_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && ctl_reg) |-> !mem_en);
endmodule

bind pagewin_xlat pagewin_chk #(.REG_BASE(REG_BASE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cpu_en   (cpu_en),
    .cpu_addr (cpu_addr),
    .mem_en   (mem_en),
    .mem_addr (mem_addr),
    .page_o   (page_o),
    .stk_err  (stk_err),
    .far_call (far_call),
    .far_page (far_page),
    .stk_full (stk_full),
    .lptr     (lptr)
);

// File: tb/pagewin_xlat_test.sv
`timescale 1ns/1ps
module pagewin_xlat_test;
    localparam logic [15:0] RB = 16'h0070;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_en = 0, cpu_we = 0, far_call = 0, far_ret = 0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0, far_page = '0;
    logic [7:0]  cpu_rdata, mem_wdata, mem_rdata, page_o;
    logic        mem_en, mem_we, stk_err;
    logic [21:0] mem_addr;

    int checks = 0;
    int fails  = 0;

    int m_page, m_ptr;
    bit m_err;
    int m_stk[$];

    always #4 clk = ~clk;

    assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ {2'b00, mem_addr[21:16]};

    pagewin_xlat uut (
        .clk(clk), .rst(rst), .cpu_en(cpu_en), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .far_call(far_call), .far_ret(far_ret), .far_page(far_page),
        .page_o(page_o), .stk_err(stk_err)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int rd_of(input int a);
        return (a & 255) ^ ((a >> 8) & 255) ^ ((a >> 16) & 63);
    endfunction

    // compare every output against the model, then advance one clock
    task automatic step(input bit en, input bit we, input int a, input int wd,
                        input bit c, input bit r, input int fp, input string tag);
        int  ofs;
        bit  is_reg, is_port;
        int  e_addr, e_rd;
        bit  e_en;
        cpu_en = en; cpu_we = we; cpu_addr = a[15:0]; cpu_wdata = wd[7:0];
        far_call = c; far_ret = r; far_page = fp[7:0];
        #1;
        ofs     = a - int'(RB);
        is_reg  = (ofs >= 0) && (ofs <= 3);
        is_port = (ofs == 4);
        if (is_port)                          e_addr = m_ptr;
        else if (a >= 'h8000 && a <= 'hBFFF)  e_addr = m_page * 16384 + (a & 'h3FFF);
        else                                  e_addr = a;
        e_en = en && !is_reg;
        if (!is_reg) e_addr = e_addr & 'h3FFFFF;
        if (!is_reg) chk(tag, "mem_addr", int'(mem_addr), e_addr);
        chk(tag, "mem_en", int'(mem_en), int'(e_en));
        chk(tag, "mem_we", int'(mem_we), int'(e_en && we));
        if (e_en && we) chk(tag, "mem_wdata", int'(mem_wdata), wd & 255);
        if (en && !we) begin
            case (ofs)
                0:       e_rd = m_page;
                1:       e_rd = (m_ptr >> 16) & 63;
                2:       e_rd = (m_ptr >> 8) & 255;
                3:       e_rd = m_ptr & 255;
                default: e_rd = rd_of(e_addr);
            endcase
            chk(tag, "cpu_rdata", int'(cpu_rdata), e_rd);
        end
        chk(tag, "page_o", int'(page_o), m_page);
        chk(tag, "stk_err", int'(stk_err), int'(m_err));
        @(posedge clk);
        if (c) begin
            if (m_stk.size() == 8) m_err = 1;
            else begin m_stk.push_back(m_page); m_page = fp & 255; end
        end else if (r) begin
            if (m_stk.size() == 0) m_err = 1;
            else m_page = m_stk.pop_back();
        end else if (en && we && ofs == 0) begin
            m_page = wd & 255;
        end
        if (en && is_port) m_ptr = (m_ptr + 1) & 'h3FFFFF;
        else if (en && we && ofs == 1) m_ptr = (m_ptr & 'hFFFF) | ((wd & 63) << 16);
        else if (en && we && ofs == 2) m_ptr = (m_ptr & 'h3F00FF) | ((wd & 255) << 8);
        else if (en && we && ofs == 3) m_ptr = (m_ptr & 'h3FFF00) | (wd & 255);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cpu_en = 0; far_call = 0; far_ret = 0;
        repeat (2) @(posedge clk);
        m_page = 0; m_ptr = 0; m_err = 0; m_stk.delete();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        step(1, 0, a, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input int a, input int d, input string tag);
        step(1, 1, a, d, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset values visible through the register block
        rd(int'(RB), "R1"); rd(int'(RB) + 1, "R1"); rd(int'(RB) + 2, "R1"); rd(int'(RB) + 3, "R1");
        // R2 / R3: window edges with bank 0 and with a nonzero bank
        rd('h7FFF, "R3"); rd('h8000, "R2"); rd('hBFFF, "R2"); rd('hC000, "R3");
        rd('h0000, "R3"); rd('hFFFF, "R3");
        wr('h1234, 'hA5, "R3");
        // R4: bank write takes effect on the following access
        step(1, 1, int'(RB), 'h5A, 0, 0, 0, "R4");
        rd('h8123, "R4"); rd('hBFFF, "R4"); rd(int'(RB), "R4");
        wr('h9000, 'h3C, "R2");
        // R12: control registers do not reach memory
        wr(int'(RB) + 2, 'h11, "R12"); rd(int'(RB) + 2, "R12");
        // R8: underflow on empty store, then stickiness
        step(0, 0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 0, 'h21, "R8");
        step(0, 0, 0, 0, 0, 1, 0, "R8");
        rd('h8000, "R8");
        do_reset();
        // R5: eight good calls
        for (int i = 1; i <= 8; i++) step(0, 0, 0, 0, 1, 0, i * 3, "R5");
        rd('h8001, "R5");
        // R7: ninth call overflows
        step(0, 0, 0, 0, 1, 0, 'hEE, "R7");
        rd('hA000, "R7");
        // R6: returns unwind in order
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1, 0, "R6");
        rd('hB000, "R6");
        do_reset();
        // R13: call beats simultaneous return and bank write
        step(1, 1, int'(RB), 'h77, 1, 1, 'h42, "R13");
        rd(int'(RB), "R13");
        step(1, 1, int'(RB), 'h66, 0, 1, 0, "R13");
        rd(int'(RB), "R13");
        // R9: pointer byte loads and readback, upper bits masked
        wr(int'(RB) + 1, 'hFF, "R9"); wr(int'(RB) + 2, 'hFF, "R9"); wr(int'(RB) + 3, 'hFE, "R9");
        rd(int'(RB) + 1, "R9"); rd(int'(RB) + 2, "R9"); rd(int'(RB) + 3, "R9");
        // R10 / R11: data port steps across the top of the space
        rd(int'(RB) + 4, "R10"); wr(int'(RB) + 4, 'h99, "R10");
        rd(int'(RB) + 4, "R11");
        rd(int'(RB) + 1, "R11"); rd(int'(RB) + 3, "R11");
        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            int k, a;
            k = $urandom_range(0, 9);
            case (k)
                0: a = int'(RB) + $urandom_range(0, 4);
                1, 2, 3: a = 'h8000 + $urandom_range(0, 'h3FFF);
                default: a = $urandom_range(0, 'hFFFF);
            endcase
            step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, a, $urandom_range(0, 255),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0, $urandom_range(0, 255),
                 "R2/R5/R6/R10");
        end
        finish_run();
    end
endmodule